// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block finds the page table entry that translates an effective address, given the virtual segment identifier of the segment that address falls in. The page table lives in ordinary memory as a power-of-two array of 64-byte groups. Each group holds eight 8-byte entries. The block reaches memory through a single request/acknowledge read/write port, one 32-bit word per transfer.

A lookup starts with a one-cycle `start` pulse while the block is idle. The block then walks the primary group one entry at a time. If nothing there matches, it walks the secondary group, which is addressed through the complemented hash. The first matching entry ends the walk. On a hit, the block sets the referenced bit in the entry's second word, and also sets the changed bit when the access is a write. It stores that word back only if its value actually changed.

The block then raises `done` for one cycle. The result outputs carry the hit flag, the real address, the entry's byte offset inside the table and a write-permission flag, and they hold those values until the next lookup starts. The write-permission flag is dropped for reads of pages that are still clean, so that a later store comes back through the searcher to mark the page dirty.

Top module: `hpt_searcher`

## Requirements
- R1: After reset, `mem_req`, `done` and `hit` are all 0.
- R2: The page index is `eff_addr[27:12]`, and the abbreviated page index is its top six bits, `eff_addr[27:22]`. An entry matches in pass p (p is 0 for primary, 1 for secondary) only when all of these hold:
  - first word bit 31 (valid) is 1;
  - first word bit 6 (hash select) equals p;
  - first word bits 30:7 equal `vsid`;
  - first word bits 5:0 equal the abbreviated page index.
- R3: The hash is `vsid[18:0]` XOR the page index, zero-extended to 32 bits. The primary group offset is (hash << 6) AND `tbl_mask`. The secondary group offset uses the 32-bit complement of the hash in the same formula. Slot s of a group starts at `tbl_base` + group offset + 8·s, and its second word is 4 bytes further on.
- R4: Slots are visited in order 0 to 7, and the first match wins. The secondary group is visited only when no slot of the primary group matches.
- R5: When neither group holds a match, the lookup ends with `done` pulsed for one cycle and `hit` = 0, after 16 first-word reads.
- R6: On a hit, the stored second word has bit 8 (referenced) set. For a write it also has bit 7 (changed) set. `wr_perm` is 1 for a write, and for a read it equals the entry's old changed bit.
- R7: The second word is written back, at its own address, only when the new value differs from the old one. Otherwise the lookup makes no write.
- R8: On a hit, `real_addr` is second-word bits 31:12 joined with `eff_addr[11:0]`, and `entry_off` is the group offset + 8·slot.
- R9: Each transfer holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`. The second word is read only for a slot whose first word matched, so a hit in pass p at slot s costs 8·p + s + 2 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a lookup when the block is idle |
| vsid | input | 24 | Virtual segment identifier |
| eff_addr | input | 32 | Effective address to translate |
| is_write | input | 1 | The access being translated is a store |
| tbl_base | input | 32 | Byte address of the page table |
| tbl_mask | input | 32 | Mask applied to scaled hash to form group offset |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle pulse at the end of a lookup |
| hit | output | 1 | A matching entry was found |
| real_addr | output | 32 | Translated real address |
| entry_off | output | 32 | Byte offset of the matching entry in the table |
| wr_perm | output | 1 | Write permission after clean-page clamping |

## Verification
The bench runs random lookups against a table filled with random words. It plants matches in the primary or the secondary group, and adds decoys: entries with the right tag but the wrong hash-select bit, and entries with the right tag but the valid bit clear. These cases separate a correct pass check from one that ignores the pass or the valid bit. Directed cases place two matches in one group, a match in the last primary slot alongside a secondary match, and a match only in the last secondary slot; these expose wrong scan order and wrong pass ordering. The referenced and changed bits are preset in every combination for both reads and writes. Counting the reads and writes on the memory port then tells an unconditional write-back, or an eager second-word read, apart from the required behaviour. Runs are made with two different base and mask pairs.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int WORD_W  = 32;
  localparam int V_BIT   = 31;
  localparam int H_BIT   = 6;
  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_CMP,
    ST_RD1,
    ST_WB,
    ST_DONE
  } walk_st_t;
endpackage

// File: rtl/hpt_hash_gen.sv
module hpt_hash_gen #(
  parameter int VSID_W    = 24,
  parameter int ADDR_W    = 32,
  parameter int PIDX_W    = 16,
  parameter int HASH_W    = 19,
  parameter int API_SHIFT = 10,
  parameter int GRP_SHIFT = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pgidx,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] tag,
  output logic [ADDR_W-1:0] prim_off,
  output logic [ADDR_W-1:0] sec_off
);
  localparam int API_W = PIDX_W - API_SHIFT;

  logic [ADDR_W-1:0] hash;
  logic [API_W-1:0]  api;

  always_comb begin
    api      = pgidx[PIDX_W-1:API_SHIFT];
    hash     = ADDR_W'(vsid[HASH_W-1:0]) ^ ADDR_W'(pgidx);
    tag      = (ADDR_W'(vsid) << (API_W + 1)) | ADDR_W'(api);
    prim_off = (hash << GRP_SHIFT) & mask;
    sec_off  = ((~hash) << GRP_SHIFT) & mask;
  end
endmodule

// File: rtl/hpt_entry_cmp.sv
module hpt_entry_cmp
  import hpt_pkg::*;
#(
  parameter int PG_BITS = 12
) (
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] tag,
  input  logic              pass,
  input  logic              is_write,
  input  logic [WORD_W-1:0] eff_addr,
  output logic              match,
  output logic [WORD_W-1:0] new_word1,
  output logic              need_wb,
  output logic              wr_perm,
  output logic [WORD_W-1:0] real_addr
);
  localparam logic [WORD_W-1:0] FLAG_MASK = (WORD_W'(1) << V_BIT) | (WORD_W'(1) << H_BIT);
  localparam logic [WORD_W-1:0] PG_MASK   = (WORD_W'(1) << PG_BITS) - 1;

  logic [WORD_W-1:0] set_bits;

  always_comb begin
    match     = word0[V_BIT] && (word0[H_BIT] == pass) && ((word0 & ~FLAG_MASK) == tag);
    set_bits  = WORD_W'(1) << REF_BIT;
    if (is_write) set_bits = set_bits | (WORD_W'(1) << CHG_BIT);
    new_word1 = word1 | set_bits;
    need_wb   = new_word1 != word1;
    wr_perm   = is_write | word1[CHG_BIT];
    real_addr = (word1 & ~PG_MASK) | (eff_addr & PG_MASK);
  end
endmodule

// File: rtl/hpt_walk_ctrl.sv
module hpt_walk_ctrl
  import hpt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              accept,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] prim_off,
  input  logic [ADDR_W-1:0] sec_off,
  input  logic              match,
  input  logic              need_wb,
  input  logic [WORD_W-1:0] new_word1,
  input  logic              wr_perm_in,
  input  logic [ADDR_W-1:0] real_in,
  output logic              pass,
  output logic [WORD_W-1:0] word0,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              hit,
  output logic [ADDR_W-1:0] real_addr,
  output logic [ADDR_W-1:0] entry_off,
  output logic              wr_perm
);
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);
  localparam int W1_OFS     = WORD_W / 8;

  walk_st_t          st_q, st_d;
  logic              pass_q, pass_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [WORD_W-1:0] w0_q, w0_d, w1_q, w1_d;
  logic              hit_q, hit_d, perm_q, perm_d;
  logic [ADDR_W-1:0] real_q, real_d, off_q, off_d;
  logic [ADDR_W-1:0] cur_off, ent_addr;

  always_comb begin
    cur_off  = (pass_q ? sec_off : prim_off) + (ADDR_W'(slot_q) << SLOT_SHIFT);
    ent_addr = base + cur_off;
  end

  always_comb begin
    st_d      = st_q;
    pass_d    = pass_q;
    slot_d    = slot_q;
    w0_d      = w0_q;
    w1_d      = w1_q;
    hit_d     = hit_q;
    perm_d    = perm_q;
    real_d    = real_q;
    off_d     = off_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ent_addr;
    mem_wdata = w1_q;
    accept    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          pass_d = 1'b0;
          slot_d = '0;
          hit_d  = 1'b0;
          perm_d = 1'b0;
          st_d   = ST_RD0;
        end
      end
      ST_RD0: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          w0_d = mem_rdata;
          st_d = ST_CMP;
        end
      end
      ST_CMP: begin
        if (match) begin
          st_d = ST_RD1;
        end else if (slot_q == SLOT_W'(SLOTS - 1)) begin
          slot_d = '0;
          if (!pass_q) begin
            pass_d = 1'b1;
            st_d   = ST_RD0;
          end else begin
            st_d = ST_DONE;
          end
        end else begin
          slot_d = slot_q + 1'b1;
          st_d   = ST_RD0;
        end
      end
      ST_RD1: begin
        mem_req  = 1'b1;
        mem_addr = ent_addr + ADDR_W'(W1_OFS);
        if (mem_ack) begin
          hit_d  = 1'b1;
          perm_d = wr_perm_in;
          real_d = real_in;
          off_d  = cur_off;
          w1_d   = new_word1;
          st_d   = need_wb ? ST_WB : ST_DONE;
        end
      end
      ST_WB: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = ent_addr + ADDR_W'(W1_OFS);
        if (mem_ack) st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pass_q <= 1'b0;
      slot_q <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
      hit_q  <= 1'b0;
      perm_q <= 1'b0;
      real_q <= '0;
      off_q  <= '0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
      slot_q <= slot_d;
      w0_q   <= w0_d;
      w1_q   <= w1_d;
      hit_q  <= hit_d;
      perm_q <= perm_d;
      real_q <= real_d;
      off_q  <= off_d;
    end
  end

  assign pass      = pass_q;
  assign word0     = w0_q;
  assign done      = (st_q == ST_DONE);
  assign hit       = hit_q;
  assign real_addr = real_q;
  assign entry_off = off_q;
  assign wr_perm   = perm_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R6
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[REF_BIT]);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/hpt_searcher.sv
module hpt_searcher
  import hpt_pkg::*;
#(
  parameter int VSID_W     = 24,
  parameter int ADDR_W     = 32,
  parameter int SEG_BITS   = 28,
  parameter int PG_BITS    = 12,
  parameter int HASH_W     = 19,
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VSID_W-1:0] vsid,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_mask,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic              hit,
  output logic [ADDR_W-1:0] real_addr,
  output logic [ADDR_W-1:0] entry_off,
  output logic              wr_perm
);
  localparam int PIDX_W    = SEG_BITS - PG_BITS;
  localparam int GRP_SHIFT = $clog2(SLOTS * SLOT_BYTES);

  logic              accept, pass, match, need_wb, perm_c;
  logic [VSID_W-1:0] vsid_q;
  logic [ADDR_W-1:0] ea_q, base_q, mask_q;
  logic              wr_q;
  logic [ADDR_W-1:0] tag, prim_off, sec_off, word0, new_word1, real_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsid_q <= '0;
      ea_q   <= '0;
      wr_q   <= 1'b0;
      base_q <= '0;
      mask_q <= '0;
    end else if (accept) begin
      vsid_q <= vsid;
      ea_q   <= eff_addr;
      wr_q   <= is_write;
      base_q <= tbl_base;
      mask_q <= tbl_mask;
    end
  end

  hpt_hash_gen #(
    .VSID_W(VSID_W), .ADDR_W(ADDR_W), .PIDX_W(PIDX_W),
    .HASH_W(HASH_W), .API_SHIFT(10), .GRP_SHIFT(GRP_SHIFT)
  ) u_hash (
    .vsid    (vsid_q),
    .pgidx   (ea_q[SEG_BITS-1:PG_BITS]),
    .mask    (mask_q),
    .tag     (tag),
    .prim_off(prim_off),
    .sec_off (sec_off)
  );

  hpt_entry_cmp #(.PG_BITS(PG_BITS)) u_cmp (
    .word0    (word0),
    .word1    (mem_rdata),
    .tag      (tag),
    .pass     (pass),
    .is_write (wr_q),
    .eff_addr (ea_q),
    .match    (match),
    .new_word1(new_word1),
    .need_wb  (need_wb),
    .wr_perm  (perm_c),
    .real_addr(real_c)
  );

  hpt_walk_ctrl #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .base      (base_q),
    .prim_off  (prim_off),
    .sec_off   (sec_off),
    .match     (match),
    .need_wb   (need_wb),
    .new_word1 (new_word1),
    .wr_perm_in(perm_c),
    .real_in   (real_c),
    .pass      (pass),
    .word0     (word0),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .done      (done),
    .hit       (hit),
    .real_addr (real_addr),
    .entry_off (entry_off),
    .wr_perm   (wr_perm)
  );

  // R8
  page_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (real_addr[PG_BITS-1:0] == ea_q[PG_BITS-1:0]));

  // R6
  store_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit && wr_q) |-> wr_perm);

  // R8
  entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (entry_off[$clog2(SLOT_BYTES)-1:0] == '0));
endmodule

// File: tb/sim_hpt_searcher.sv
module sim_hpt_searcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] vsid = '0;
  logic [31:0] eff_addr = '0;
  logic        is_write = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [31:0] tbl_mask = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, hit, wr_perm;
  logic [31:0] real_addr, entry_off;

  logic [31:0] mem [0:4095];
  int          rd_cnt = 0, wr_cnt = 0;
  int          checks = 0, errors = 0;

  logic        exp_hit, exp_perm, exp_wr;
  logic [31:0] exp_off, exp_real, exp_w1;
  logic [11:0] exp_w1idx;
  int          exp_rd;

  always #10 clk = ~clk;

  hpt_searcher u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vsid(vsid), .eff_addr(eff_addr),
    .is_write(is_write), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .hit(hit),
    .real_addr(real_addr), .entry_off(entry_off), .wr_perm(wr_perm)
  );

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack && (($urandom % 3) != 0)) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[mem_addr[13:2]];
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        rd_cnt = rd_cnt + 1;
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] group_off(input logic [23:0] v, input logic [31:0] ea,
                                            input logic [31:0] mask, input int p);
    logic [31:0] h;
    h = {13'b0, v[18:0]} ^ {16'b0, ea[27:12]};
    if (p != 0) h = ~h;
    return (h << 6) & mask;
  endfunction

  task automatic model();
    logic [31:0] g, a, w0, w1, nw;
    exp_hit = 1'b0; exp_rd = 0; exp_wr = 1'b0; exp_perm = 1'b0;
    exp_off = '0; exp_real = '0; exp_w1 = '0; exp_w1idx = '0;
    for (int p = 0; p < 2; p++) begin
      if (!exp_hit) begin
        g = group_off(vsid, eff_addr, tbl_mask, p);
        for (int s = 0; s < 8; s++) begin
          if (!exp_hit) begin
            a  = tbl_base + g + 32'(s * 8);
            w0 = mem[a[13:2]];
            exp_rd++;
            if (w0[31] && (w0[6] == p[0]) && (w0[30:7] == vsid) && (w0[5:0] == eff_addr[27:22])) begin
              exp_hit   = 1'b1;
              exp_rd++;
              exp_off   = g + 32'(s * 8);
              w1        = mem[a[13:2] + 12'd1];
              exp_real  = {w1[31:12], eff_addr[11:0]};
              exp_perm  = is_write | w1[7];
              nw        = w1 | 32'h100 | (is_write ? 32'h80 : 32'h0);
              exp_wr    = (nw != w1);
              exp_w1    = nw;
              exp_w1idx = a[13:2] + 12'd1;
            end
          end
        end
      end
    end
  endtask

  task automatic fill_groups();
    logic [31:0] g;
    for (int p = 0; p < 2; p++) begin
      g = group_off(vsid, eff_addr, tbl_mask, p);
      for (int s = 0; s < 16; s++) mem[(tbl_base[13:2] + g[13:2]) + 12'(s)] = $urandom;
    end
  endtask

  task automatic plant(input int p, input int s, input logic valid, input logic hsel, input logic [1:0] rc);
    logic [31:0] a;
    a = tbl_base + group_off(vsid, eff_addr, tbl_mask, p) + 32'(s * 8);
    mem[a[13:2]] = {valid, vsid, hsel, eff_addr[27:22]};
    mem[a[13:2] + 12'd1] = {$urandom} & 32'hFFFF_FE7F | {23'b0, rc, 7'b0};
  endtask

  task automatic run_lookup();
    int wd;
    logic [31:0] old_w1;
    model();
    old_w1 = mem[exp_w1idx];
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wd = 0;
    while (!done && wd < 2000) begin @(negedge clk); wd++; end
    if (wd >= 2000) begin
      check(1'b0, "R5 watchdog", 32'(wd), 32'd0);
      return;
    end
    check(hit == exp_hit, "R2/R4 hit", {31'b0, hit}, {31'b0, exp_hit});
    check(rd_cnt == exp_rd, "R9 reads", 32'(rd_cnt), 32'(exp_rd));
    check(wr_cnt == (exp_wr ? 1 : 0), "R7 writes", 32'(wr_cnt), exp_wr ? 32'd1 : 32'd0);
    if (exp_hit) begin
      check(real_addr == exp_real, "R8 real_addr", real_addr, exp_real);
      check(entry_off == exp_off, "R3/R8 entry_off", entry_off, exp_off);
      check(wr_perm == exp_perm, "R6 wr_perm", {31'b0, wr_perm}, {31'b0, exp_perm});
      check(mem[exp_w1idx] == exp_w1, "R6 word1", mem[exp_w1idx], exp_w1);
      if (!exp_wr) check(mem[exp_w1idx] == old_w1, "R7 unchanged", mem[exp_w1idx], old_w1);
    end else begin
      check(exp_rd == 16, "R5 miss reads", 32'(exp_rd), 32'd16);
    end
    @(negedge clk);
    check(!done, "R5 done pulse", {31'b0, done}, 32'd0);
  endtask

  task automatic new_addr();
    vsid = 24'($urandom);
    eff_addr = $urandom;
    is_write = $urandom % 2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4096; i++) mem[i] = $urandom;
    tbl_base = 32'h2000; tbl_mask = 32'h1FC0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!mem_req && !done && !hit, "R1 reset", {29'b0, mem_req, done, hit}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !done && !hit, "R1 idle", {29'b0, mem_req, done, hit}, 32'd0);

    // R4 two primary matches: slot 2 wins over slot 5
    new_addr(); fill_groups(); plant(0, 2, 1, 0, 2'b00); plant(0, 5, 1, 0, 2'b11); run_lookup();
    check(entry_off[5:0] == 6'd16, "R4 first slot", entry_off, 32'd16);
    // R4 primary slot 7 beats secondary slot 0
    new_addr(); fill_groups(); plant(0, 7, 1, 0, 2'b01); plant(1, 0, 1, 1, 2'b01); run_lookup();
    // R4 only last secondary slot
    new_addr(); fill_groups(); plant(1, 7, 1, 1, 2'b10); run_lookup();
    // R2 decoys: wrong hash select in primary, invalid in secondary
    new_addr(); fill_groups(); plant(0, 3, 1, 1, 2'b00); plant(1, 3, 0, 1, 2'b00); run_lookup();
    // R7 read, R and C already set: no write; R6 read clean: no write permission
    new_addr(); is_write = 0; fill_groups(); plant(0, 1, 1, 0, 2'b11); run_lookup();
    new_addr(); is_write = 0; fill_groups(); plant(0, 1, 1, 0, 2'b00); run_lookup();
    new_addr(); is_write = 0; fill_groups(); plant(1, 4, 1, 1, 2'b10); run_lookup();
    new_addr(); is_write = 1; fill_groups(); plant(0, 6, 1, 0, 2'b11); run_lookup();
    new_addr(); is_write = 1; fill_groups(); plant(0, 6, 1, 0, 2'b10); run_lookup();

    for (int i = 0; i < 160; i++) begin
      if (i == 80) begin tbl_base = 32'h0; tbl_mask = 32'h3FC0; end
      new_addr(); fill_groups();
      case ($urandom % 5)
        0: ;
        1: plant(0, $urandom % 8, 1, 0, 2'($urandom));
        2: plant(1, $urandom % 8, 1, 1, 2'($urandom));
        3: begin plant(0, $urandom % 8, 1, 1, 2'($urandom)); plant(1, $urandom % 8, 1, 1, 2'($urandom)); end
        default: begin plant(0, $urandom % 8, 0, 0, 2'($urandom)); plant(1, $urandom % 8, $urandom % 2, 1, 2'($urandom)); end
      endcase
      run_lookup();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule